// File: doc/BRIEF.md
# Flash Embedded-Operation Controller

This block is the command and sequencing core of a byte-wide flash memory. It sits behind a strobe-driven host bus and in front of a small memory model that holds the flash array. The array is scaled down so that a 64 KB sector becomes 64 bytes by default. Host write strobes go through an unlock-sequence decoder. Once a full command has been written, the block runs an embedded program or an embedded erase. Erase first drives every targeted byte to zero and then fills the targeted sectors with ones, and each phase is timed by an internal down-counter.

While an operation runs, `ready_o` is low and array reads return a status byte instead of data. An erase can be suspended, so that the host can read from sectors outside the erase set or program bytes there, and then resumed. Sectors flagged in `prot_i` are never written. A low-supply flag blocks every command cycle. The asynchronous reset aborts any operation and returns the block to array reads. The eleven sectors form a boot layout: one quarter-size, two eighth-size, one half-size and seven full-size sectors. `TOP_BOOT` places the small sectors at the top or at the bottom of the address space.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After reset, `ready_o` is 1 and `rdata_o` is 0x00. A read returns the array byte at `addr_i` in the cycle after the `re_i` strobe.
- R2: The program command is four writes: 0xAA to 0x155, 0x55 to 0x0AA, 0xA0 to 0x155, then the data to the target address. With the 9-bit default address, 0x155 and 0x0AA are 0x555 and 0x2AA truncated. The byte then holds the old value AND the new value, and `ready_o` is 0 while the program runs.
- R3: A command cycle that breaks the unlock sequence returns the block to read mode, so a following lone data write changes nothing.
- R4: While busy, a read returns a status byte. Bit 7 is the complement of bit 7 of the program data, and 0 during an erase. Bit 6 inverts on every busy read. Bits 5..0 are 0.
- R5: Sector erase is 0xAA@0x155, 0x55@0x0AA, 0x80@0x155, 0xAA@0x155, 0x55@0x0AA, then 0x30 to any address in the sector. Every byte of that sector then reads 0xFF, and all other sectors are unchanged.
- R6: A further 0x30 written to another sector while the acceptance window is still open adds that sector to the same erase.
- R7: Chip erase ends in 0x10@0x155 instead of the sector write, and leaves every sector at 0xFF.
- R8: A sector whose `prot_i` bit is 1 is never written, whether by program or by erase.
- R9: 0xB0 written during an erase suspends it: `ready_o` is 1 on the next cycle. Reads outside the erase set return array data, and reads inside it return 0x80.
- R10: While suspended, a program to a sector outside the erase set completes, and a program into the erase set is ignored. Then 0x30 to any address resumes the erase to completion.
- R11: While `vlow_i` is 1, no write cycle has any effect.
- R12: Asserting `rst_ni` mid-operation aborts it. The block then returns to array reads and accepts new commands.
- R13: With `TOP_BOOT`=1, the sector 10 range is 0x1F0..0x1FF and the sector 9 range is 0x1E8..0x1EF. Erasing sector 10 leaves 0x1EF unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, aborts any operation |
| vlow_i | input | 1 | Low-supply flag; blocks all write cycles |
| we_i | input | 1 | Write strobe, one cycle per bus write |
| re_i | input | 1 | Read strobe, one cycle per bus read |
| addr_i | input | AW | Byte address (9 bits by default) |
| wdata_i | input | 8 | Write data / command byte |
| prot_i | input | 11 | Per-sector protect flags |
| rdata_o | output | 8 | Array data or status byte, registered |
| ready_o | output | 1 | 1 when idle or suspended, 0 while an operation runs |

## Verification
A read strobe and the suspend write can land in the same cycle, because the bus has separate read and write strobes and one shared address. The bench raises `re_i` and `we_i` with 0xB0 together while an erase is walking the array, using an address whose array content has bit 7 set. The returned byte must be the erase status (bit 7 clear, bits 5..0 zero), since the read is judged against the state before the edge, and `ready_o` must be high on the next cycle. A later read of the same address must return plain array data.

// File: rtl/flash_pkg.sv
package flash_pkg;
  localparam int NSECT = 11;
  localparam int SECW  = 4;

  typedef enum logic [3:0] {
    ST_READ, ST_C1, ST_C2, ST_PDATA, ST_E1, ST_E2, ST_E3, ST_EWIN,
    ST_PROG, ST_PRE, ST_PREW, ST_ERASE, ST_FILL, ST_SUSP
  } state_e;

  localparam logic [7:0] CMD_KEY_A = 8'hAA;
  localparam logic [7:0] CMD_KEY_B = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ERSU  = 8'h80;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_SUSP  = 8'hB0;
endpackage

// File: rtl/flash_sector_map.sv
module flash_sector_map
  import flash_pkg::*;
#(
  parameter int UNIT_LG  = 0,
  parameter bit TOP_BOOT = 1'b1,
  localparam int AW = 9 + UNIT_LG
) (
  input  logic [AW-1:0]   addr_i,
  output logic [SECW-1:0] sec_o
);
  logic [8:0] u;
  assign u = addr_i[AW-1:UNIT_LG];

  if (TOP_BOOT) begin : g_top
    always_comb begin
      if (u < 9'd448)      sec_o = {1'b0, u[8:6]};
      else if (u < 9'd480) sec_o = 4'd7;
      else if (u < 9'd488) sec_o = 4'd8;
      else if (u < 9'd496) sec_o = 4'd9;
      else                 sec_o = 4'd10;
    end
  end else begin : g_bot
    always_comb begin
      if (u < 9'd16)       sec_o = 4'd0;
      else if (u < 9'd24)  sec_o = 4'd1;
      else if (u < 9'd32)  sec_o = 4'd2;
      else if (u < 9'd64)  sec_o = 4'd3;
      else                 sec_o = 4'd3 + {1'b0, u[8:6]};
    end
  end
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int AW = 9,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [7:0]    rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [7:0]    rdata_b_o
);
  logic [7:0] mem_q [DEPTH];

  // cell contents survive reset
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/flash_timer.sv
module flash_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          done_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_pkg::*;
#(
  parameter int UNIT_LG     = 0,
  parameter bit TOP_BOOT    = 1'b1,
  parameter int TW          = 16,
  parameter int PGM_TICKS   = 8,
  parameter int ERASE_TICKS = 32,
  parameter int WIN_TICKS   = 16,
  localparam int AW = 9 + UNIT_LG
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vlow_i,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [7:0]       wdata_i,
  input  logic [NSECT-1:0] prot_i,
  output logic [7:0]       rdata_o,
  output logic             ready_o
);
  // command addresses, truncated to the array width (AW <= 12)
  localparam logic [11:0]   KEY1_F = 12'h555;
  localparam logic [11:0]   KEY2_F = 12'h2AA;
  localparam logic [AW-1:0] KEY1_A = KEY1_F[AW-1:0];
  localparam logic [AW-1:0] KEY2_A = KEY2_F[AW-1:0];
  localparam logic [TW-1:0] PTK = TW'(PGM_TICKS);
  localparam logic [TW-1:0] ETK = TW'(ERASE_TICKS);
  localparam logic [TW-1:0] WTK = TW'(WIN_TICKS);

  state_e st_q, st_d, rs_q, rs_d;
  logic             susp_q, susp_d;
  logic [NSECT-1:0] esel_q, esel_d;
  logic [AW-1:0]    walk_q, walk_d, pa_q, pa_d;
  logic [7:0]       pd_q, pd_d, rdata_q;
  logic             tog_q;

  logic          tmr_ld, tmr_done;
  logic [TW-1:0] tmr_val;
  logic          arr_we;
  logic [AW-1:0] arr_wa;
  logic [7:0]    arr_wd, host_rd, rd_b;

  // sector decode for host, walker and write port
  logic [AW-1:0]   map_addr [3];
  logic [SECW-1:0] map_sec  [3];
  assign map_addr[0] = addr_i;
  assign map_addr[1] = walk_q;
  assign map_addr[2] = arr_wa;

  for (genvar g = 0; g < 3; g++) begin : g_map
    flash_sector_map #(.UNIT_LG(UNIT_LG), .TOP_BOOT(TOP_BOOT)) u_map (
      .addr_i(map_addr[g]),
      .sec_o (map_sec[g])
    );
  end

  logic [SECW-1:0] hsec, wsec, wr_sec;
  assign hsec   = map_sec[0];
  assign wsec   = map_sec[1];
  assign wr_sec = map_sec[2];

  flash_array #(.AW(AW)) u_array (
    .clk_i    (clk_i),
    .we_i     (arr_we),
    .waddr_i  (arr_wa),
    .wdata_i  (arr_wd),
    .raddr_a_i(addr_i),
    .rdata_a_o(host_rd),
    .raddr_b_i((st_q == ST_PROG) ? pa_q : walk_q),
    .rdata_b_o(rd_b)
  );

  flash_timer #(.TW(TW)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_ld),
    .val_i (tmr_val),
    .done_o(tmr_done)
  );

  logic wr_ok, busy, erase_act, walk_last, walk_hit, key1, key2;
  logic [NSECT-1:0] hbit;
  state_e base_st;

  assign wr_ok     = we_i && !vlow_i;
  assign key1      = (wdata_i == CMD_KEY_A) && (addr_i == KEY1_A);
  assign key2      = (wdata_i == CMD_KEY_B) && (addr_i == KEY2_A);
  assign busy      = st_q inside {ST_EWIN, ST_PROG, ST_PRE, ST_PREW, ST_ERASE, ST_FILL};
  assign erase_act = st_q inside {ST_PRE, ST_PREW, ST_ERASE, ST_FILL};
  assign base_st   = susp_q ? ST_SUSP : ST_READ;
  assign walk_last = &walk_q;
  assign walk_hit  = esel_q[wsec] && !prot_i[wsec];
  assign ready_o   = !busy;
  assign rdata_o   = rdata_q;

  always_comb begin
    hbit = '0;
    hbit[hsec] = 1'b1;
  end

  always_comb begin
    st_d = st_q; rs_d = rs_q; susp_d = susp_q; esel_d = esel_q;
    walk_d = walk_q; pa_d = pa_q; pd_d = pd_q;
    tmr_ld = 1'b0; tmr_val = '0;
    arr_we = 1'b0; arr_wa = walk_q; arr_wd = 8'hFF;
    case (st_q)
      ST_READ, ST_SUSP: if (wr_ok) begin
        if (key1) st_d = ST_C1;
        else if (st_q == ST_SUSP && wdata_i == CMD_SECT) begin
          st_d = rs_q; susp_d = 1'b0;
          if (rs_q == ST_ERASE) begin tmr_ld = 1'b1; tmr_val = ETK; end
        end
      end
      ST_C1: if (wr_ok) st_d = key2 ? ST_C2 : base_st;
      ST_C2: if (wr_ok) begin
        st_d = base_st;
        if (addr_i == KEY1_A && wdata_i == CMD_PROG) st_d = ST_PDATA;
        else if (addr_i == KEY1_A && wdata_i == CMD_ERSU && !susp_q) st_d = ST_E1;
      end
      ST_PDATA: if (wr_ok) begin
        pa_d = addr_i; pd_d = wdata_i;
        if (prot_i[hsec] || (susp_q && esel_q[hsec])) st_d = base_st;
        else begin st_d = ST_PROG; tmr_ld = 1'b1; tmr_val = PTK; end
      end
      ST_E1: if (wr_ok) st_d = key1 ? ST_E2 : ST_READ;
      ST_E2: if (wr_ok) st_d = key2 ? ST_E3 : ST_READ;
      ST_E3: if (wr_ok) begin
        st_d = ST_READ;
        if (wdata_i == CMD_CHIP && addr_i == KEY1_A) begin
          esel_d = '1; walk_d = '0; st_d = ST_PRE;
        end else if (wdata_i == CMD_SECT) begin
          esel_d = hbit; st_d = ST_EWIN; tmr_ld = 1'b1; tmr_val = WTK;
        end
      end
      ST_EWIN: begin
        if (wr_ok) begin
          if (wdata_i == CMD_SECT) begin
            esel_d = esel_q | hbit; tmr_ld = 1'b1; tmr_val = WTK;
          end else begin
            esel_d = '0; st_d = ST_READ;
          end
        end else if (tmr_done) begin
          walk_d = '0; st_d = ST_PRE;
        end
      end
      ST_PROG: if (tmr_done) begin
        arr_we = 1'b1; arr_wa = pa_q; arr_wd = pd_q & rd_b;
        st_d = base_st;
      end
      default: begin
        if (wr_ok && wdata_i == CMD_SUSP) begin
          // suspend preempts this cycle's step
          susp_d = 1'b1; st_d = ST_SUSP;
          rs_d = (st_q == ST_PREW) ? ST_PRE : st_q;
        end else begin
          case (st_q)
            ST_PRE: begin
              if (walk_hit && rd_b != 8'h00) begin
                st_d = ST_PREW; tmr_ld = 1'b1; tmr_val = PTK;
              end else if (walk_last) begin
                st_d = ST_ERASE; tmr_ld = 1'b1; tmr_val = ETK;
              end else walk_d = walk_q + 1'b1;
            end
            ST_PREW: if (tmr_done) begin
              arr_we = 1'b1; arr_wd = 8'h00;
              if (walk_last) begin
                st_d = ST_ERASE; tmr_ld = 1'b1; tmr_val = ETK;
              end else begin
                walk_d = walk_q + 1'b1; st_d = ST_PRE;
              end
            end
            ST_ERASE: if (tmr_done) begin walk_d = '0; st_d = ST_FILL; end
            ST_FILL: begin
              arr_we = walk_hit; arr_wd = 8'hFF;
              if (walk_last) begin st_d = ST_READ; esel_d = '0; end
              else walk_d = walk_q + 1'b1;
            end
            default: ;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_READ; rs_q <= ST_PRE; susp_q <= 1'b0; esel_q <= '0;
      walk_q <= '0; pa_q <= '0; pd_q <= '0;
    end else begin
      st_q <= st_d; rs_q <= rs_d; susp_q <= susp_d; esel_q <= esel_d;
      walk_q <= walk_d; pa_q <= pa_d; pd_q <= pd_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0; tog_q <= 1'b0;
    end else if (re_i) begin
      if (busy) begin
        rdata_q <= {(st_q == ST_PROG) ? ~pd_q[7] : 1'b0, tog_q, 6'b0};
        tog_q   <= ~tog_q;
      end else if (susp_q && esel_q[hsec]) begin
        rdata_q <= 8'h80;
      end else begin
        rdata_q <= host_rd;
      end
    end
  end
endmodule

// File: rtl/flash_seq_ctrl_chk.sv
module flash_seq_ctrl_chk #(
  parameter int NS = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          vlow_i,
  input logic          we_i,
  input logic          re_i,
  input logic [7:0]    wdata_i,
  input logic [NS-1:0] prot_i,
  input logic [7:0]    rdata_o,
  input logic          ready_o,
  input logic          arr_we,
  input logic [3:0]    arr_wsec,
  input logic          erase_act
);
  // R8
  no_prot_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(arr_we && prot_i[arr_wsec]));

  // R4
  status_low_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !ready_o) |=> (rdata_o[5:0] == 6'b0));

  // R4
  status_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !ready_o && $past(re_i && !ready_o)) |=> (rdata_o[6] != $past(rdata_o[6])));

  // R11
  vlow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && vlow_i) |=> ready_o);

  // R9
  suspend_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_act && we_i && !vlow_i && wdata_i == 8'hB0) |=> ready_o);
endmodule

bind flash_seq_ctrl flash_seq_ctrl_chk #(.NS(11)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .vlow_i   (vlow_i),
  .we_i     (we_i),
  .re_i     (re_i),
  .wdata_i  (wdata_i),
  .prot_i   (prot_i),
  .rdata_o  (rdata_o),
  .ready_o  (ready_o),
  .arr_we   (arr_we),
  .arr_wsec (wr_sec),
  .erase_act(erase_act)
);

// File: tb/flash_seq_ctrl_test.sv
module flash_seq_ctrl_test;
  localparam int AW = 9;

  logic clk = 1'b0, rst_n = 1'b0, vlow = 1'b0, we = 1'b0, re = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata, r1, r2;
  logic [10:0] prot = '0;
  logic ready;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  flash_seq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .vlow_i(vlow), .we_i(we), .re_i(re),
    .addr_i(addr), .wdata_i(wdata), .prot_i(prot), .rdata_o(rdata), .ready_o(ready)
  );

  // {addr, program data, expected byte}
  localparam logic [24:0] VEC [6] = '{
    {9'h010, 8'hA5, 8'hA5}, {9'h010, 8'h3C, 8'h24}, {9'h1F0, 8'h0F, 8'h0F},
    {9'h1E8, 8'h80, 8'h80}, {9'h040, 8'h00, 8'h00}, {9'h1C0, 8'hF1, 8'hF1}
  };

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    wr(9'h155, 8'hAA); wr(9'h0AA, 8'h55); wr(9'h155, 8'hA0); wr(a, d);
  endtask

  task automatic erase_pre();
    wr(9'h155, 8'hAA); wr(9'h0AA, 8'h55); wr(9'h155, 8'h80);
    wr(9'h155, 8'hAA); wr(9'h0AA, 8'h55);
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (!ready && n < 20000) begin @(negedge clk); n++; end
    chk(ready, req, ready, 1);
  endtask

  task automatic expect_byte(input logic [AW-1:0] a, input logic [7:0] e, input string req);
    logic [7:0] v;
    rd(a, v);
    chk(v == e, req, v, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ready == 1'b1, "R1 ready after reset", ready, 1);
    chk(rdata == 8'h00, "R1 rdata after reset", rdata, 0);
    rst_n = 1'b1;

    // R7 chip erase
    erase_pre(); wr(9'h155, 8'h10);
    chk(ready == 1'b0, "R7 busy after chip erase", ready, 0);
    wait_ready("R7 chip erase done");
    for (int s = 0; s < 8; s++) expect_byte(AW'(s * 64 + 5), 8'hFF, "R7 erased");
    expect_byte(9'h1E9, 8'hFF, "R7 erased s9");
    expect_byte(9'h1FE, 8'hFF, "R7 erased s10");

    // R2 program table
    for (int i = 0; i < 6; i++) begin
      prog(VEC[i][24:16], VEC[i][15:8]);
      chk(ready == 1'b0, "R2 busy during program", ready, 0);
      wait_ready("R2 program done");
      expect_byte(VEC[i][24:16], VEC[i][7:0], "R2 programmed AND");
    end

    // R4 status reads during program
    prog(9'h100, 8'h5A);
    rd(9'h100, r1); rd(9'h100, r2);
    chk(r1[7] == 1'b1 && r1[5:0] == 6'b0, "R4 status byte", r1, 8'h80);
    chk(r2[6] != r1[6], "R4 toggle bit", r2[6], ~r1[6]);
    wait_ready("R4 program done");
    expect_byte(9'h100, 8'h5A, "R4 data after done");

    // R3 broken sequence
    wr(9'h155, 8'hAA); wr(9'h0AA, 8'h55); wr(9'h155, 8'h77);
    wr(9'h020, 8'h00);
    chk(ready == 1'b1, "R3 no operation started", ready, 1);
    expect_byte(9'h020, 8'hFF, "R3 byte untouched");

    // R11 low supply
    vlow = 1'b1;
    prog(9'h030, 8'h00);
    chk(ready == 1'b1, "R11 no busy under low supply", ready, 1);
    vlow = 1'b0;
    expect_byte(9'h030, 8'hFF, "R11 byte untouched");

    // R8 protection
    prot = 11'b100_0000_0000;
    prog(9'h1F4, 8'h00);
    wait_ready("R8 protected program");
    expect_byte(9'h1F4, 8'hFF, "R8 program ignored");
    erase_pre(); wr(9'h1F0, 8'h30);
    wait_ready("R8 protected erase");
    expect_byte(9'h1F0, 8'h0F, "R8 erase ignored");
    prot = '0;

    // R5 / R13 sector erase of sector 10
    prog(9'h1EF, 8'h11); wait_ready("R13 setup");
    erase_pre(); wr(9'h1F0, 8'h30);
    wait_ready("R5 sector erase done");
    expect_byte(9'h1F0, 8'hFF, "R5 target erased");
    expect_byte(9'h1FF, 8'hFF, "R5 target end erased");
    expect_byte(9'h1EF, 8'h11, "R13 boundary byte kept");
    expect_byte(9'h1E8, 8'h80, "R5 neighbour kept");

    // R6 multi-sector erase
    erase_pre(); wr(9'h010, 8'h30); wr(9'h1C0, 8'h30);
    wait_ready("R6 erase done");
    expect_byte(9'h010, 8'hFF, "R6 first sector erased");
    expect_byte(9'h1C0, 8'hFF, "R6 added sector erased");
    expect_byte(9'h100, 8'h5A, "R6 other sector kept");
    expect_byte(9'h040, 8'h00, "R6 sector 1 kept");

    // R9 / R10 suspend and resume
    prog(9'h008, 8'h00); wait_ready("R9 setup");
    erase_pre(); wr(9'h000, 8'h30);
    repeat (40) @(negedge clk);
    chk(ready == 1'b0, "R9 erasing before suspend", ready, 0);
    @(negedge clk); addr = 9'h1C0; wdata = 8'hB0; we = 1'b1; re = 1'b1;
    @(negedge clk); we = 1'b0; re = 1'b0;
    chk(rdata[7] == 1'b0 && rdata[5:0] == 6'b0, "R9 same-cycle read is status", rdata, 8'h00);
    chk(ready == 1'b1, "R9 ready when suspended", ready, 1);
    expect_byte(9'h1C0, 8'hFF, "R9 outside read after suspend");
    expect_byte(9'h100, 8'h5A, "R9 outside read");
    expect_byte(9'h008, 8'h80, "R9 inside read");
    prog(9'h110, 8'h33); wait_ready("R10 suspended program");
    expect_byte(9'h110, 8'h33, "R10 suspended program data");
    prog(9'h004, 8'h00);
    @(negedge clk);
    chk(ready == 1'b1, "R10 program into erase set ignored", ready, 1);
    wr(9'h000, 8'h30);
    chk(ready == 1'b0, "R10 busy after resume", ready, 0);
    wait_ready("R10 resumed erase done");
    expect_byte(9'h008, 8'hFF, "R10 erase completed");
    expect_byte(9'h004, 8'hFF, "R10 erase set byte");
    expect_byte(9'h110, 8'h33, "R10 suspended program kept");

    // R12 reset abort
    erase_pre(); wr(9'h155, 8'h10);
    repeat (20) @(negedge clk);
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
    chk(ready == 1'b1, "R12 ready after abort", ready, 1);
    expect_byte(9'h100, 8'h5A, "R12 array read after abort");
    prog(9'h120, 8'h0F); wait_ready("R12 program after abort");
    expect_byte(9'h120, 8'h0F, "R12 command accepted after abort");

    summary();
    $finish;
  end
endmodule